// File: doc/BRIEF.md
# Dual-channel serial DAC load interface

This block is the digital front end of a two-channel 12-bit converter. It takes three slow serial pins: a serial clock, a serial data line, and one active-low select line that also serves as the load strobe. It oversamples them in a fast system clock domain and shifts in a 24-bit frame. When the select line is released, it copies the frame into two 12-bit channel registers at the same time. The two parallel codes are the outputs that would drive the converters.

The select line gates the serial clock inside the block. While select is high, serial clock activity has no effect. If the serial clock is already high when select falls, the gated clock shows a rising edge at that moment. That extra edge shifts in one bit, and the block reports it on a violation output. A frame whose length is not 24 still loads the last 24 bits shifted in, and an error flag is raised. A reset synchroniser, asserted asynchronously and released synchronously, clears all state at power-on.

Top module: `dual_dac_load_if`

## Requirements
- R1: While reset is asserted, and afterwards until the first load, both channel codes are 0 and `upd_o`, `len_err_o` and `edge_viol_o` are 0. A reset in the middle of a frame discards the bits shifted so far.
- R2: A frame is 24 bits. The first 12 bits go to `ch_a_o` and the next 12 bits go to `ch_b_o`. Within each channel the most significant bit is sent first.
- R3: The data pin is sampled on each rising edge of the serial clock while select is low. Serial clock edges while select is high shift nothing.
- R4: A low-to-high transition of the select pin loads both channel registers in the same cycle. The outputs change on the third system clock edge after the pin changes, and at no other time.
- R5: `upd_o` is a pulse exactly one cycle wide, produced once per load in the cycle in which the new codes first appear.
- R6: A falling edge of select while the serial clock is high shifts in the data bit present at that moment. It also gives a one-cycle pulse on `edge_viol_o`, three system clock edges after the select pin falls.
- R7: At each load, `len_err_o` becomes 1 if the number of bits shifted since select fell is not 24, and 0 otherwise. The flag keeps that value until the next load. The channels always take the last 24 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin |
| sdata_i | input | 1 | Serial data pin |
| csld_i | input | 1 | Active-low select, load on rising edge |
| ch_a_o | output | 12 | Channel A code |
| ch_b_o | output | 12 | Channel B code |
| upd_o | output | 1 | One-cycle pulse when the channel codes are loaded |
| len_err_o | output | 1 | Last loaded frame did not have 24 bits |
| edge_viol_o | output | 1 | Pulse: select fell while the serial clock was high |

## Verification
Each pin passes through two synchroniser flops and one register that detects edges. A load, its update pulse and the violation pulse are therefore due on the third system clock edge after the pin changes. The bench changes pins on falling clock edges. After the second rising edge it checks that the old codes are still present, after the third it checks the new codes and the pulse, and one edge later it checks that the pulse has ended. Each serial clock phase is held for two system clocks, so every edge reaches the logic. The expected codes come from a 24-bit shift model in the bench that counts bits, including the extra bit caused by a violating select edge.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int unsigned DEF_CH_W    = 12;
  localparam int unsigned DEF_SYNC    = 2;
  localparam int unsigned PIN_COUNT   = 3;

  typedef struct packed {
    logic csld;
    logic sclk;
    logic sdata;
  } serial_pins_t;

  localparam serial_pins_t PINS_IDLE = '{csld: 1'b1, sclk: 1'b0, sdata: 1'b0};
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_int_n = stg_q[1];
endmodule

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned    W       = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) stg_q[s] <= RST_VAL;
      else          stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int unsigned FRAME_W = 24,
  localparam int unsigned CNT_W  = $clog2(FRAME_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n_i,
  input  logic               sclk_s_i,
  input  logic               sdata_s_i,
  input  logic               csld_s_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               load_o,
  output logic               frame_ok_o,
  output logic               viol_o
);
  logic               sclk_q, csld_q;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               viol_q, viol_d;
  logic               gate_now, gate_prev, shift_en, cs_fall, cs_rise;

  assign gate_now  = sclk_s_i & ~csld_s_i;
  assign gate_prev = sclk_q & ~csld_q;
  assign shift_en  = gate_now & ~gate_prev;
  assign cs_fall   = csld_q & ~csld_s_i;
  assign cs_rise   = ~csld_q & csld_s_i;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    viol_d = cs_fall & sclk_s_i;
    if (shift_en) begin
      sh_d = {sh_q[FRAME_W-2:0], sdata_s_i};
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
    if (cs_rise) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sclk_q <= 1'b0;
      csld_q <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      csld_q <= csld_s_i;
      viol_q <= viol_d;
      if (shift_en || cs_rise) cnt_q <= cnt_d;
      if (shift_en)            sh_q  <= sh_d;
    end
  end

  assign frame_o    = sh_q;
  assign load_o     = cs_rise;
  assign frame_ok_o = (cnt_q == CNT_W'(FRAME_W));
  assign viol_o     = viol_q;

  // R3: with select high on both sides of an edge, the frame cannot move
  a_r3_hold_while_deselected: assert property (@(posedge clk) disable iff (!rst_n_i)
    (csld_q && csld_s_i) |=> $stable(sh_q));
  // R6: violation indication lasts one cycle
  a_r6_viol_single: assert property (@(posedge clk) disable iff (!rst_n_i)
    viol_q |=> !viol_q);
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int unsigned CH_W = 12,
  localparam int unsigned FRAME_W = 2 * CH_W
) (
  input  logic               clk,
  input  logic               rst_n_i,
  input  logic               load_i,
  input  logic               frame_ok_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CH_W-1:0]    ch_a_o,
  output logic [CH_W-1:0]    ch_b_o,
  output logic               upd_o,
  output logic               len_err_o
);
  logic [CH_W-1:0] a_q, a_d, b_q, b_d;
  logic            upd_q, err_q, err_d;

  always_comb begin
    a_d   = frame_i[FRAME_W-1:CH_W];
    b_d   = frame_i[CH_W-1:0];
    err_d = ~frame_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      a_q   <= '0;
      b_q   <= '0;
      err_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        a_q   <= a_d;
        b_q   <= b_d;
        err_q <= err_d;
      end
    end
  end

  assign ch_a_o    = a_q;
  assign ch_b_o    = b_q;
  assign upd_o     = upd_q;
  assign len_err_o = err_q;

  // R5: update pulse is never wider than one cycle
  a_r5_upd_single: assert property (@(posedge clk) disable iff (!rst_n_i)
    upd_q |=> !upd_q);
  // R7: the length flag moves only together with a load
  a_r7_err_with_upd: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$stable(err_q) |-> upd_q);
endmodule

// File: rtl/dual_dac_load_if.sv
module dual_dac_load_if
  import dual_dac_pkg::*;
#(
  parameter int unsigned CH_W        = DEF_CH_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            csld_i,
  output logic [CH_W-1:0] ch_a_o,
  output logic [CH_W-1:0] ch_b_o,
  output logic            upd_o,
  output logic            len_err_o,
  output logic            edge_viol_o
);
  localparam int unsigned FRAME_W = 2 * CH_W;

  logic               rst_int_n;
  serial_pins_t       pins_raw, pins_syn;
  logic [FRAME_W-1:0] frame;
  logic               load, frame_ok;

  dac_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign pins_raw = '{csld: csld_i, sclk: sclk_i, sdata: sdata_i};

  dac_pin_sync #(
    .W       (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk     (clk),
    .rst_n_i (rst_int_n),
    .d_i     (pins_raw),
    .q_o     (pins_syn)
  );

  dac_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n_i    (rst_int_n),
    .sclk_s_i   (pins_syn.sclk),
    .sdata_s_i  (pins_syn.sdata),
    .csld_s_i   (pins_syn.csld),
    .frame_o    (frame),
    .load_o     (load),
    .frame_ok_o (frame_ok),
    .viol_o     (edge_viol_o)
  );

  dac_chan_regs #(.CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst_n_i    (rst_int_n),
    .load_i     (load),
    .frame_ok_i (frame_ok),
    .frame_i    (frame),
    .ch_a_o     (ch_a_o),
    .ch_b_o     (ch_b_o),
    .upd_o      (upd_o),
    .len_err_o  (len_err_o)
  );

  // R4: channel codes change only in a cycle flagged by the update pulse
  a_r4_change_only_on_upd: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable({ch_a_o, ch_b_o}) |-> upd_o);
endmodule

// File: tb/dual_dac_load_if_tb.sv
module dual_dac_load_if_tb_top;
  localparam time CLK_P = 10ns;
  localparam int  CW    = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, sdata = 1'b0, csld = 1'b1;
  logic [CW-1:0] ch_a, ch_b;
  logic          upd, len_err, viol;

  int            n_chk = 0, n_fail = 0;
  logic [23:0]   m_sh = '0;
  logic [CW-1:0] exp_a = '0, exp_b = '0;
  logic          exp_err = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_dac_load_if dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .csld_i(csld),
    .ch_a_o(ch_a), .ch_b_o(ch_b), .upd_o(upd), .len_err_o(len_err),
    .edge_viol_o(viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [23:0] shift_in(input logic [23:0] s, input logic b);
    return {s[22:0], b};
  endfunction

  // n bits, bits[n-1] first; glitch: first bit enters via select falling with sclk high
  task automatic send_frame(input int n, input logic [63:0] bits, input bit glitch);
    int start = 0;
    @(negedge clk);
    if (glitch && n > 0) begin
      sdata = bits[n-1]; sclk = 1'b1;
      wait_neg(3);
      csld = 1'b0;
      m_sh = shift_in(m_sh, bits[n-1]);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R6 viol not early", 32'(viol), 0);
      @(posedge clk); @(negedge clk);
      chk("R6 viol pulse", 32'(viol), 1);
      @(posedge clk); @(negedge clk);
      chk("R6 viol one cycle", 32'(viol), 0);
      sclk = 1'b0;
      wait_neg(2);
      start = 1;
    end else begin
      sclk = 1'b0;
      csld = 1'b0;
      wait_neg(2);
    end
    for (int i = start; i < n; i++) begin
      sdata = bits[n-1-i];
      wait_neg(2);
      sclk = 1'b1;
      m_sh = shift_in(m_sh, bits[n-1-i]);
      wait_neg(2);
      sclk = 1'b0;
    end
    wait_neg(2);
    csld = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 old A before load", 32'(ch_a), 32'(exp_a));
    chk("R5 no early upd", 32'(upd), 0);
    exp_a   = m_sh[23:12];
    exp_b   = m_sh[11:0];
    exp_err = (n != 24);
    @(posedge clk); @(negedge clk);
    chk("R2 ch A", 32'(ch_a), 32'(exp_a));
    chk("R2 ch B", 32'(ch_b), 32'(exp_b));
    chk("R5 upd pulse", 32'(upd), 1);
    chk("R7 len err", 32'(len_err), 32'(exp_err));
    @(posedge clk); @(negedge clk);
    chk("R5 upd one cycle", 32'(upd), 0);
    wait_neg(2);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd1448));
    wait_neg(4);
    chk("R1 reset A", 32'(ch_a), 0);
    chk("R1 reset upd", 32'(upd), 0);
    rst_n = 1'b1;
    wait_neg(6);
    chk("R1 after reset A", 32'(ch_a), 0);
    chk("R1 after reset B", 32'(ch_b), 0);
    chk("R1 after reset err", 32'(len_err), 0);
    chk("R1 after reset viol", 32'(viol), 0);

    send_frame(24, 64'hFFF_000, 0);        // R2 split
    send_frame(24, 64'h801_A5C, 0);        // R2 msb first
    send_frame(30, 64'h2A_5A5_C3C, 0);     // R7 long
    send_frame(20, 64'h9_1234, 0);         // R7 short: older bits remain
    send_frame(24, 64'hC00_003, 1);        // R6 extra edge counts as a bit
    // R3: clock activity while deselected is ignored
    for (int i = 0; i < 5; i++) begin
      sdata = 1'($urandom()); sclk = 1'b1; wait_neg(2); sclk = 1'b0; wait_neg(2);
    end
    send_frame(0, 64'h0, 0);
    chk("R3 no shift while high A", 32'(ch_a), 32'(exp_a));

    // R1: reset mid-frame discards partial bits
    @(negedge clk); csld = 1'b0; wait_neg(2);
    for (int i = 0; i < 10; i++) begin
      sdata = 1'b1; wait_neg(2); sclk = 1'b1; wait_neg(2); sclk = 1'b0;
    end
    rst_n = 1'b0; wait_neg(3);
    chk("R1 mid reset A", 32'(ch_a), 0);
    rst_n = 1'b1; wait_neg(6);
    m_sh = '0; exp_a = '0; exp_b = '0;
    csld = 1'b1;
    wait_neg(5);
    chk("R1 mid reset discards A", 32'(ch_a), 0);
    chk("R1 mid reset discards B", 32'(ch_b), 0);

    for (int k = 0; k < 25; k++) begin
      int n;
      r = {$urandom(), $urandom()};
      n = ($urandom() % 10 < 7) ? 24 : 16 + int'($urandom() % 17);
      send_frame(n, r, ($urandom() % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule